// File: doc/BRIEF.md
# Integer Execution Unit with Instruction Decode

This block is the integer execute stage of a small 32-bit processor core. It takes one raw 32-bit instruction word together with the two source operand values that the register file has already read, and the address of the instruction. From these it works out the operation and produces a result one clock later. It covers register-register and register-immediate arithmetic, logic, shifts and comparisons, loading an upper immediate, and adding an upper immediate to the instruction address.

The decoder pulls apart the instruction fields and sign-extends the immediate. It picks the operation from the opcode, the 3-bit function code and the 7-bit function code. Bit 30 of the instruction tells subtract from add, and arithmetic from logical right shift. Encodings outside the supported set raise an illegal flag instead of writing a result. A destination of register 0 never produces a write, because that register is hard-wired to zero.

The registered destination index and write-enable go straight to the register file write port.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the registered result, destination index, write-enable and illegal flag to zero, even when a valid instruction is presented during reset.
- R2: With opcode 0110011 (register-register), the function code in bits 14:12 selects the operation: 000 add, 001 left shift, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 right shift, 110 or, 111 and. The result appears on the clock edge that samples the valid strobe.
- R3: Bits 31:25 equal to 0100000 select subtract for function code 000 and arithmetic right shift for 101. Bits 31:25 equal to 0000000 select add and logical right shift.
- R4: With opcode 0010011 (register-immediate), the second operand is bits 31:20, sign-extended in two's complement to 32 bits. The same function code table applies, except that function code 000 is always an add.
- R5: Shifts use only the low 5 bits of the shift amount: the second source operand, or bits 24:20 for the immediate form. Logical shifts fill with zeros. Arithmetic right shift fills with the sign bit. For immediate right shifts, bit 30 picks arithmetic.
- R6: Signed less-than treats 0xFFFFFFFF as smaller than 1. Unsigned less-than treats it as larger. Both return 1 or 0.
- R7: Opcode 0110111 yields bits 31:12 of the instruction with the low 12 bits zero. Opcode 0010111 yields the instruction address plus that same value.
- R8: The destination index is bits 11:7. When it is 0, the result and index are still registered, but write-enable stays low.
- R9: An unknown opcode raises the illegal flag, with write-enable low and the result 0. So does a bits-31:25 value other than 0000000 or 0100000, or 0100000 paired with a function code other than 000 or 101. The same bit 31:25 rule applies to immediate shifts.
- R10: A cycle without the valid strobe leaves write-enable and the illegal flag low on the next edge, and holds the result and destination index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| pc | input | 32 | Address of the instruction |
| res_q | output | 32 | Registered result |
| rd_q | output | 5 | Registered destination register index |
| wr_q | output | 1 | Registered register-file write-enable |
| ill_q | output | 1 | Registered illegal-encoding flag |

## Verification
Every output of this unit is due exactly one rising edge after the cycle in which the instruction was presented. This holds for results, the illegal flag, and the hold behaviour of idle cycles. The driver applies each instruction, or an idle cycle, at a falling edge and queues the outcome it expects. The monitor pops one entry a short delay after each following rising edge, so each queued value is compared against the outputs of precisely the edge that should have produced it. Back-to-back instructions and idle gaps therefore line up without any extra latency bookkeeping.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned SHW    = $clog2(XLEN);
    localparam int unsigned REGW   = 5;
    localparam int unsigned IMMW   = 12;
    localparam int unsigned UIMMW  = 20;

    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
        OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
    } alu_op_e;

    typedef enum logic [1:0] {
        ASEL_REG, ASEL_PC, ASEL_ZERO
    } a_sel_e;

    typedef struct packed {
        alu_op_e          op;
        a_sel_e           a_sel;
        logic             b_imm;
        logic [XLEN-1:0]  imm;
        logic             illegal;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]  res;
        logic [REGW-1:0]  rd;
        logic             wr;
        logic             ill;
    } exu_state_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import alu_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       f7_base;
    logic       f7_alt;
    logic       unused_fields;

    assign opc     = insn[6:0];
    assign f3      = insn[14:12];
    assign f7      = insn[31:25];
    assign f7_base = (f7 == F7_BASE);
    assign f7_alt  = (f7 == F7_ALT);

    // source and destination indices are handled outside this decoder
    assign unused_fields = ^{insn[19:15], insn[11:7]};

    always_comb begin
        dec         = '0;
        dec.op      = OP_ADD;
        dec.a_sel   = ASEL_REG;
        dec.b_imm   = 1'b0;
        dec.imm     = {{(XLEN-IMMW){insn[31]}}, insn[31:20]};
        dec.illegal = 1'b0;

        unique case (opc)
            OPC_REG: begin
                unique case (f3)
                    3'b000: begin
                        if (f7_base)     dec.op = OP_ADD;
                        else if (f7_alt) dec.op = OP_SUB;
                        else             dec.illegal = 1'b1;
                    end
                    3'b101: begin
                        if (f7_base)     dec.op = OP_SRL;
                        else if (f7_alt) dec.op = OP_SRA;
                        else             dec.illegal = 1'b1;
                    end
                    default: begin
                        unique case (f3)
                            3'b001:  dec.op = OP_SLL;
                            3'b010:  dec.op = OP_SLT;
                            3'b011:  dec.op = OP_SLTU;
                            3'b100:  dec.op = OP_XOR;
                            3'b110:  dec.op = OP_OR;
                            default: dec.op = OP_AND;
                        endcase
                        dec.illegal = !f7_base;
                    end
                endcase
            end
            OPC_IMM: begin
                dec.b_imm = 1'b1;
                unique case (f3)
                    3'b000: dec.op = OP_ADD;
                    3'b001: begin
                        dec.op      = OP_SLL;
                        dec.illegal = !f7_base;
                    end
                    3'b010: dec.op = OP_SLT;
                    3'b011: dec.op = OP_SLTU;
                    3'b100: dec.op = OP_XOR;
                    3'b101: begin
                        if (f7_base)     dec.op = OP_SRL;
                        else if (f7_alt) dec.op = OP_SRA;
                        else             dec.illegal = 1'b1;
                    end
                    3'b110: dec.op = OP_OR;
                    default: dec.op = OP_AND;
                endcase
            end
            OPC_LUI: begin
                dec.b_imm = 1'b1;
                dec.a_sel = ASEL_ZERO;
                dec.imm   = {insn[31:12], {(XLEN-UIMMW){1'b0}}};
            end
            OPC_AUIPC: begin
                dec.b_imm = 1'b1;
                dec.a_sel = ASEL_PC;
                dec.imm   = {insn[31:12], {(XLEN-UIMMW){1'b0}}};
            end
            default: dec.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int unsigned W   = 32,
    parameter int unsigned AMW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [AMW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   dout
);

    logic [W-1:0] stg [0:AMW];
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic         fill;

    // a left shift is a right shift of the bit-reversed word
    always_comb begin
        for (int i = 0; i < W; i++) begin
            rev_in[i] = din[W-1-i];
        end
    end

    assign fill   = arith & din[W-1];
    assign stg[0] = left ? rev_in : din;

    genvar s;
    generate
        for (s = 0; s < AMW; s++) begin : g_stage
            localparam int unsigned SH = 1 << s;
            assign stg[s+1] = amt[s] ? {{SH{fill}}, stg[s][W-1:SH]} : stg[s];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < W; i++) begin
            rev_out[i] = stg[AMW][W-1-i];
        end
    end

    assign dout = left ? rev_out : stg[AMW];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import alu_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic [XLEN-1:0] sh_out;
    logic            lt_s;
    logic            lt_u;

    exu_shifter #(.W(XLEN), .AMW(SHW)) u_shift (
        .din   (a),
        .amt   (b[SHW-1:0]),
        .left  (op == OP_SLL),
        .arith (op == OP_SRA),
        .dout  (sh_out)
    );

    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:  y = a ^ b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            default: y = sh_out;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] res_q,
    output logic [REGW-1:0] rd_q,
    output logic            wr_q,
    output logic            ill_q
);

    dec_t            dec;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_y;
    exu_state_t      st_d;
    exu_state_t      st_q;

    exu_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    always_comb begin
        unique case (dec.a_sel)
            ASEL_PC:   opa = pc;
            ASEL_ZERO: opa = '0;
            default:   opa = src_a;
        endcase
        opb = dec.b_imm ? dec.imm : src_b;
    end

    exu_alu u_alu (
        .op (dec.op),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        st_d.ill = 1'b0;
        if (in_valid) begin
            st_d.rd = insn[11:7];
            if (dec.illegal) begin
                st_d.res = '0;
                st_d.ill = 1'b1;
            end else begin
                st_d.res = alu_y;
                st_d.wr  = (insn[11:7] != '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_q = st_q.res;
    assign rd_q  = st_q.rd;
    assign wr_q  = st_q.wr;
    assign ill_q = st_q.ill;

endmodule

// File: rtl/int_exec_chk.sv
module int_exec_chk
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] res_q,
    input  logic [REGW-1:0] rd_q,
    input  logic            wr_q,
    input  logic            ill_q
);

    logic known_opc;
    assign known_opc = (insn[6:0] == OPC_REG) || (insn[6:0] == OPC_IMM) ||
                       (insn[6:0] == OPC_LUI) || (insn[6:0] == OPC_AUIPC);

    assert_x0_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> (rd_q != '0));

    assert_ill_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_q && ill_q));

    assert_bad_opc_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !known_opc) |=> (ill_q && !wr_q && res_q == '0));

    assert_upper_imm_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[6:0] == OPC_LUI) |=>
            (res_q == {$past(insn[31:12]), 12'b0}));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_q && !ill_q && $stable(res_q) && $stable(rd_q)));

    assert_wr_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> $past(in_valid));

endmodule

bind int_exec_unit int_exec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .insn     (insn),
    .res_q    (res_q),
    .rd_q     (rd_q),
    .wr_q     (wr_q),
    .ill_q    (ill_q)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] pc = '0;
    logic [31:0] res_q;
    logic [4:0]  rd_q;
    logic        wr_q;
    logic        ill_q;

    int total = 0;
    int bad   = 0;
    bit go    = 1'b0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  rd;
        logic        wr;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] last_res = '0;
    logic [4:0]  last_rd  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .src_a(src_a), .src_b(src_b), .pc(pc),
        .res_q(res_q), .rd_q(rd_q), .wr_q(wr_q), .ill_q(ill_q)
    );

    function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, 5'd2, 5'd1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] itype(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
        return {imm, 5'd1, f3, rd, 7'b0010011};
    endfunction

    function automatic logic [31:0] utype(input logic [19:0] imm, input logic [6:0] opc, input logic [4:0] rd);
        return {imm, rd, opc};
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] p, input logic [31:0] eres,
                         input logic ewr, input logic eill, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; insn = ins; src_a = a; src_b = b; pc = p;
        e.res = eres; e.rd = ins[11:7]; e.wr = ewr; e.ill = eill; e.tag = tag;
        sb.push_back(e);
        last_res = eres; last_rd = ins[11:7];
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; insn = 32'hFFFF_FFFF; src_a = 32'h1234_5678; src_b = 32'h9;
        e.res = last_res; e.rd = last_rd; e.wr = 1'b0; e.ill = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: one expected item per rising edge, sampled just after it
    initial begin
        exp_t e;
        wait (go);
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                total++;
                if (res_q !== e.res || rd_q !== e.rd || wr_q !== e.wr || ill_q !== e.ill) begin
                    bad++;
                    $display("FAIL %s: got res=%h rd=%0d wr=%b ill=%b, want res=%h rd=%0d wr=%b ill=%b",
                             e.tag, res_q, rd_q, wr_q, ill_q, e.res, e.rd, e.wr, e.ill);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running, want finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: valid add presented while reset is held
        in_valid = 1'b1; insn = rtype(7'b0000000, 3'b000, 5'd5); src_a = 32'd1; src_b = 32'd2;
        @(posedge clk); @(posedge clk); #1;
        total++;
        if (res_q !== '0 || rd_q !== '0 || wr_q !== 1'b0 || ill_q !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got res=%h rd=%0d wr=%b ill=%b, want all zero", res_q, rd_q, wr_q, ill_q);
        end
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        go = 1'b1;

        // R2 / R3 register-register
        issue(rtype(7'b0000000, 3'b000, 5'd5), 32'd10, 32'd20, 0, 32'd30, 1, 0, "R2 add");
        issue(rtype(7'b0100000, 3'b000, 5'd6), 32'd5, 32'd7, 0, 32'hFFFF_FFFE, 1, 0, "R3 sub");
        issue(rtype(7'b0000000, 3'b100, 5'd7), 32'h0000_F0F0, 32'h0000_FF00, 0, 32'h0000_0FF0, 1, 0, "R2 xor");
        issue(rtype(7'b0000000, 3'b111, 5'd8), 32'h0000_0DC0, 32'h0000_3C00, 0, 32'h0000_0C00, 1, 0, "R2 and");
        issue(rtype(7'b0000000, 3'b110, 5'd9), 32'h0000_0DC0, 32'h0000_3C00, 0, 32'h0000_3DC0, 1, 0, "R2 or");
        issue(rtype(7'b0000000, 3'b101, 5'd10), 32'h8000_0000, 32'd4, 0, 32'h0800_0000, 1, 0, "R3 srl");
        issue(rtype(7'b0100000, 3'b101, 5'd11), 32'h8000_0000, 32'd4, 0, 32'hF800_0000, 1, 0, "R3 sra");
        // R5: amount 33 uses only low 5 bits -> 1
        issue(rtype(7'b0000000, 3'b001, 5'd12), 32'd3, 32'd33, 0, 32'd6, 1, 0, "R5 sll low bits");
        // R6 signed vs unsigned
        issue(rtype(7'b0000000, 3'b010, 5'd13), 32'hFFFF_FFFF, 32'd1, 0, 32'd1, 1, 0, "R6 slt");
        issue(rtype(7'b0000000, 3'b011, 5'd14), 32'hFFFF_FFFF, 32'd1, 0, 32'd0, 1, 0, "R6 sltu");

        // R4 immediates
        issue(itype(12'hFFF, 3'b000, 5'd15), 32'd5, 32'hDEAD, 0, 32'd4, 1, 0, "R4 addi negative");
        issue(itype(12'hFFF, 3'b100, 5'd16), 32'h0000_0DC0, 32'd0, 0, 32'hFFFF_F23F, 1, 0, "R4 xori");
        issue(itype(12'h001, 3'b010, 5'd17), 32'hFFFF_FFFF, 32'd0, 0, 32'd1, 1, 0, "R6 slti");
        issue(itype(12'hFFF, 3'b011, 5'd18), 32'd1, 32'd0, 0, 32'd1, 1, 0, "R6 sltiu");
        // R5 immediate shifts
        issue(itype({7'b0100000, 5'd31}, 3'b101, 5'd19), 32'h8000_0000, 32'd0, 0, 32'hFFFF_FFFF, 1, 0, "R5 srai");
        issue(itype({7'b0000000, 5'd31}, 3'b101, 5'd20), 32'h8000_0000, 32'd0, 0, 32'd1, 1, 0, "R5 srli");
        issue(itype({7'b0000000, 5'd4}, 3'b001, 5'd21), 32'd1, 32'd0, 0, 32'h10, 1, 0, "R5 slli");

        // R7 upper immediates
        issue(utype(20'h12345, 7'b0110111, 5'd22), 32'hAAAA_AAAA, 32'd0, 32'h100, 32'h1234_5000, 1, 0, "R7 lui");
        issue(utype(20'h12345, 7'b0010111, 5'd23), 32'hAAAA_AAAA, 32'd0, 32'h100, 32'h1234_5100, 1, 0, "R7 auipc");

        // R8 destination x0
        issue(rtype(7'b0000000, 3'b000, 5'd0), 32'd10, 32'd20, 0, 32'd30, 0, 0, "R8 rd zero");

        // R10 idle cycles hold
        idle("R10 idle 1");
        idle("R10 idle 2");

        // R9 illegal encodings
        issue({25'h0, 7'b0000011}, 32'd1, 32'd2, 0, 32'd0, 0, 1, "R9 bad opcode");
        issue(rtype(7'b0000001, 3'b000, 5'd3), 32'd1, 32'd2, 0, 32'd0, 0, 1, "R9 bad funct7");
        issue(rtype(7'b0100000, 3'b100, 5'd4), 32'd1, 32'd2, 0, 32'd0, 0, 1, "R9 alt funct7 on xor");
        issue(itype({7'b0100000, 5'd3}, 3'b001, 5'd5), 32'd1, 32'd0, 0, 32'd0, 0, 1, "R9 arith slli");
        idle("R10 idle after illegal");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule